// File: doc/BRIEF.md
# PIM Command Sequencer

This block holds a small program of 32-bit processing-in-memory instructions and steps through it. It does not run freely on the clock. It advances exactly one executed instruction each time the memory controller presents a triggering command on `trig`. For each step it decodes the instruction and drives a registered issue bundle to a lane execution unit: an opcode, a destination select and two source selects. The vector datapath and the DRAM array are replaced here by a stub lane that counts the data and arithmetic operations it receives.

The host loads the program through a simple write port while PIM execution is disabled. Raising `pim_en` arms the sequencer. Arming puts the program counter at entry 0 and clears the done flag, the loop counters and the lane count. Loops are static. A JUMP carries its target and an iteration count, and costs no trigger of its own: the instruction it lands on runs on the same trigger. EXIT halts the program until the sequencer is re-armed.

Top module: `pim_cmd_seq`

## Requirements
- R1: After synchronous reset, `issue_valid`=0, `done`=0, `pc`=0 and `lane_ops`=0.
- R2: A host write is stored only while `pim_en` is low. A write made while `pim_en` is high leaves that entry unchanged.
- R3: A 0→1 change on `pim_en` sets `pc` to 0 and clears `done`, the loop counters and `lane_ops`. A trigger has no effect while `pim_en` is low.
- R4: A trigger while armed and not done executes one non-JUMP instruction. The issue bundle and `issue_valid`=1 appear at the clock edge that samples the trigger, and `pc` moves to the entry after the executed one.
- R5: Word layout and codes:
  - Fields: opcode [31:28], destination [27:26], first source [25:24], second source [23:22], jump target [20:16], jump count [7:0].
  - Opcodes: NOP=0, ADD=1, MUL=2, MAC=3, MAD=4, MOV=5, FILL=6, JUMP=7, EXIT=8. Codes 9 to 15 execute as NOP.
  - Select codes: 0 = vector file A, 1 = vector file B, 2 = scalar file, 3 = bank row.
- R6: MAC always issues destination 1 (vector B). ADD, MUL and MAD issue destination {0, bit 26}, which is always a vector file.
- R7: MUL, MAC or MAD whose first source is the scalar file (2) issues as NOP.
- R8: A JUMP goes to its target `count` times and then falls through to the next entry. Falling through reloads its counter, so a later visit loops `count` times again.
- R9: When a JUMP (taken or not) lands on another JUMP, the trigger issues NOP and `pc` becomes the address of the landed JUMP.
- R10: EXIT issues opcode 8 with zero selects, sets `done` and leaves `pc` on the EXIT entry. Later triggers issue nothing until the next arm.
- R11: `lane_ops` counts issued ADD, MUL, MAC, MAD, MOV and FILL operations. It updates one cycle after the issue.
- R12: NOP issues carry all-zero selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pim_en | input | 1 | PIM execution enable; rising edge arms |
| host_we | input | 1 | Host program write strobe |
| host_addr | input | AW (5) | Program entry to write |
| host_wdata | input | 32 | Instruction word to write |
| trig | input | 1 | Triggering memory command, one per step |
| issue_valid | output | 1 | An instruction was executed this cycle |
| issue_op | output | 4 | Issued opcode |
| issue_dst | output | 2 | Issued destination select |
| issue_src0 | output | 2 | Issued first source select |
| issue_src1 | output | 2 | Issued second source select |
| pc | output | AW (5) | Program counter |
| done | output | 1 | EXIT reached |
| lane_ops | output | LW (8) | Stub lane operation count |

## Verification
The program runs through twice, so an inner loop has to replay its full count. A counter that only reloaded at arm would fall through at once on the second pass and throw off the `pc` sequence. Back-to-back jumps and jump fall-through are both covered. A design that spent an extra trigger on a JUMP, or that resolved chained jumps, would put every later row out of step. Forced MAC destinations, scalar-first-operand rejection and undefined opcodes are checked against the issue fields. Writes made while enabled, triggers while disabled and triggers after EXIT are each checked at the ports; a design that let any of them through would show a wrong opcode, a moved `pc` or a stray `issue_valid`.

// File: rtl/pim_seq_pkg.sv
package pim_seq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 8;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_MUL  = 4'd2;
  localparam logic [3:0] OP_MAC  = 4'd3;
  localparam logic [3:0] OP_MAD  = 4'd4;
  localparam logic [3:0] OP_MOV  = 4'd5;
  localparam logic [3:0] OP_FILL = 4'd6;
  localparam logic [3:0] OP_JUMP = 4'd7;
  localparam logic [3:0] OP_EXIT = 4'd8;

  localparam logic [1:0] SEL_VA   = 2'd0;
  localparam logic [1:0] SEL_VB   = 2'd1;
  localparam logic [1:0] SEL_SCAL = 2'd2;
  localparam logic [1:0] SEL_ROW  = 2'd3;

  typedef struct packed {
    logic [3:0]       op;
    logic [1:0]       dst;
    logic [1:0]       src0;
    logic [1:0]       src1;
    logic             rsv;
    logic [4:0]       tgt;
    logic [7:0]       pad;
    logic [CNT_W-1:0] cnt;
  } instr_t;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] dst;
    logic [1:0] src0;
    logic [1:0] src1;
  } issue_t;
endpackage

// File: rtl/pim_cmd_store.sv
module pim_cmd_store #(
  parameter int DEPTH = 32,
  parameter int WW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [WW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [WW-1:0] rdata_b
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pim_jump_ctr.sv
module pim_jump_ctr #(
  parameter int DEPTH = 32,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic          take,
  input  logic [AW-1:0] idx,
  output logic [CW-1:0] taken_cnt
);
  logic [CW-1:0] ctr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ctr[g] <= '0;
      end else if (upd && idx == AW'(g)) begin
        ctr[g] <= take ? ctr[g] + 1'b1 : '0;
      end
    end
  end

  assign taken_cnt = ctr[idx];
endmodule

// File: rtl/pim_decode.sv
module pim_decode
  import pim_seq_pkg::*;
(
  input  instr_t ins,
  output issue_t iss
);
  always_comb begin
    iss = '0;
    case (ins.op)
      OP_ADD: iss = '{op: OP_ADD, dst: {1'b0, ins.dst[0]}, src0: ins.src0, src1: ins.src1};
      OP_MUL, OP_MAD: begin
        if (ins.src0 != SEL_SCAL)
          iss = '{op: ins.op, dst: {1'b0, ins.dst[0]}, src0: ins.src0, src1: ins.src1};
      end
      OP_MAC: begin
        if (ins.src0 != SEL_SCAL)
          iss = '{op: OP_MAC, dst: SEL_VB, src0: ins.src0, src1: ins.src1};
      end
      OP_MOV, OP_FILL: iss = '{op: ins.op, dst: ins.dst, src0: ins.src0, src1: ins.src1};
      OP_EXIT: iss.op = OP_EXIT;
      default: iss = '0;
    endcase
  end
endmodule

// File: rtl/pim_stub_lane.sv
module pim_stub_lane
  import pim_seq_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic [3:0]    op,
  output logic [LW-1:0] ops
);
  logic counted;
  assign counted = vld && op >= OP_ADD && op <= OP_FILL;

  always_ff @(posedge clk) begin
    if (rst || clr) ops <= '0;
    else if (counted) ops <= ops + 1'b1;
  end

  // R11
  lane_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !counted) |=> $stable(ops));
endmodule

// File: rtl/pim_cmd_seq.sv
module pim_cmd_seq
  import pim_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pim_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  input  logic          trig,
  output logic          issue_valid,
  output logic [3:0]    issue_op,
  output logic [1:0]    issue_dst,
  output logic [1:0]    issue_src0,
  output logic [1:0]    issue_src1,
  output logic [AW-1:0] pc,
  output logic          done,
  output logic [LW-1:0] lane_ops
);
  logic          en_q, arm, fire;
  logic [WORD_W-1:0] word_a, word_b;
  instr_t        ins0, ins1, exec_ins;
  issue_t        dec, iss_q;
  logic          is_jump, take, chain, is_exit;
  logic [AW-1:0] land, exec_addr, pc_next;
  logic [CNT_W-1:0] taken_cnt;

  assign arm  = pim_en && !en_q;
  assign fire = pim_en && !en_q ? 1'b0 : (pim_en && !done && trig);

  pim_cmd_store #(.DEPTH(DEPTH), .WW(WORD_W)) i_store (
    .clk(clk), .we(host_we && !pim_en), .waddr(host_addr), .wdata(host_wdata),
    .raddr_a(pc), .rdata_a(word_a), .raddr_b(land), .rdata_b(word_b)
  );

  assign ins0    = instr_t'(word_a);
  assign ins1    = instr_t'(word_b);
  assign is_jump = ins0.op == OP_JUMP;
  assign take    = taken_cnt < ins0.cnt;
  assign land    = take ? ins0.tgt[AW-1:0] : AW'(pc + 1'b1);

  pim_jump_ctr #(.DEPTH(DEPTH), .CW(CNT_W)) i_jctr (
    .clk(clk), .rst(rst), .clr(arm), .upd(fire && is_jump), .take(take),
    .idx(pc), .taken_cnt(taken_cnt)
  );

  always_comb begin
    chain     = is_jump && ins1.op == OP_JUMP;
    exec_addr = is_jump ? land : pc;
    exec_ins  = chain ? instr_t'('0) : (is_jump ? ins1 : ins0);
    is_exit   = exec_ins.op == OP_EXIT;
    if (chain || is_exit) pc_next = exec_addr;
    else                  pc_next = AW'(exec_addr + 1'b1);
  end

  pim_decode i_dec (.ins(exec_ins), .iss(dec));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      pc          <= '0;
      done        <= 1'b0;
      issue_valid <= 1'b0;
      iss_q       <= '0;
    end else begin
      en_q        <= pim_en;
      issue_valid <= fire;
      if (arm) begin
        pc   <= '0;
        done <= 1'b0;
      end else if (fire) begin
        pc    <= pc_next;
        iss_q <= dec;
        if (is_exit) done <= 1'b1;
      end
    end
  end

  assign issue_op   = iss_q.op;
  assign issue_dst  = iss_q.dst;
  assign issue_src0 = iss_q.src0;
  assign issue_src1 = iss_q.src1;

  pim_stub_lane #(.LW(LW)) i_lane (
    .clk(clk), .rst(rst), .clr(arm), .vld(issue_valid), .op(issue_op), .ops(lane_ops)
  );

  // R6
  mac_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op == OP_MAC) |-> issue_dst == SEL_VB);

  // R7
  scalar_src0_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (issue_op == OP_MUL || issue_op == OP_MAC || issue_op == OP_MAD))
      |-> issue_src0 != SEL_SCAL);

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> !issue_valid);

  // R3
  arm_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pim_en) |=> (pc == '0 && !done && !issue_valid));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $past(pim_en));
endmodule

// File: tb/test_pim_cmd_seq.sv
module test_pim_cmd_seq;
  logic clk = 1'b0, rst = 1'b1, pim_en = 1'b0, host_we = 1'b0, trig = 1'b0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic issue_valid, done;
  logic [3:0] issue_op;
  logic [1:0] issue_dst, issue_src0, issue_src1;
  logic [4:0] pc;
  logic [7:0] lane_ops;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pim_cmd_seq i_pim_cmd_seq (
    .clk(clk), .rst(rst), .pim_en(pim_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .trig(trig), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1),
    .pc(pc), .done(done), .lane_ops(lane_ops)
  );

  // expected per trigger: {op, dst, src0, src1, pc after}
  localparam int NROW = 19;
  localparam logic [14:0] TBL [NROW] = '{
    {4'd1, 2'd1, 2'd2, 2'd3, 5'd1},  // ADD, dst forced to vector (R6)
    {4'd3, 2'd1, 2'd3, 2'd2, 5'd2},  // MAC dst forced to B (R6)
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd3},  // MUL with scalar src0 -> NOP (R7, R12)
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},  // MOV
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},  // JUMP taken, target runs same trigger (R8)
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},  // JUMP taken again (R8)
    {4'd6, 2'd0, 2'd3, 2'd0, 5'd6},  // fall through to FILL (R8)
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd7},  // opcode 15 -> NOP (R5)
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd8},  // JUMP onto JUMP -> NOP (R9)
    {4'd1, 2'd1, 2'd2, 2'd3, 5'd1},  // outer loop back
    {4'd3, 2'd1, 2'd3, 2'd2, 5'd2},
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd3},
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},  // reloaded counter loops again (R8)
    {4'd5, 2'd2, 2'd0, 2'd1, 5'd4},
    {4'd6, 2'd0, 2'd3, 2'd0, 5'd6},
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd7},
    {4'd0, 2'd0, 2'd0, 2'd0, 5'd8},
    {4'd8, 2'd0, 2'd0, 2'd0, 5'd9}   // EXIT, pc stays (R10)
  };

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [1:0] d,
      input logic [1:0] s0, input logic [1:0] s1, input logic [4:0] tg, input logic [7:0] n);
    return {op, d, s0, s1, 1'b0, tg, 8'd0, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic trig_once();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); pim_en = 1'b0;
    @(negedge clk); pim_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 valid", 32'(issue_valid), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 lane", 32'(lane_ops), 0);

    hwrite(0, mk(1, 3, 2, 3, 0, 0));
    hwrite(1, mk(3, 0, 3, 2, 0, 0));
    hwrite(2, mk(2, 1, 2, 1, 0, 0));
    hwrite(3, mk(5, 2, 0, 1, 0, 0));
    hwrite(4, mk(7, 0, 0, 0, 3, 2));
    hwrite(5, mk(6, 0, 3, 0, 0, 0));
    hwrite(6, mk(15, 1, 1, 1, 0, 0));
    hwrite(7, mk(7, 0, 0, 0, 8, 0));
    hwrite(8, mk(7, 0, 0, 0, 0, 1));
    hwrite(9, mk(8, 0, 0, 0, 0, 0));

    // R3: trigger while disabled does nothing
    trig_once();
    chk("R3 idle valid", 32'(issue_valid), 0);
    chk("R3 idle pc", 32'(pc), 0);

    @(negedge clk); pim_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NROW; i++) begin
      trig_once();
      // R4 (row comments name R5..R10)
      chk($sformatf("R4 row %0d valid", i), 32'(issue_valid), 1);
      chk($sformatf("R4 row %0d issue", i),
          32'({issue_op, issue_dst, issue_src0, issue_src1, pc}), 32'(TBL[i]));
    end
    chk("R10 done", 32'(done), 1);
    trig_once();
    chk("R10 halted valid", 32'(issue_valid), 0);
    chk("R10 halted pc", 32'(pc), 9);
    @(negedge clk);
    chk("R11 lane count", 32'(lane_ops), 12);

    // R2: write while enabled is ignored
    hwrite(0, mk(8, 0, 0, 0, 0, 0));
    rearm();
    chk("R3 arm pc", 32'(pc), 0);
    chk("R3 arm done", 32'(done), 0);
    chk("R3 arm lane", 32'(lane_ops), 0);
    trig_once();
    chk("R2 blocked write", 32'({issue_op, issue_dst, issue_src0, issue_src1}), 32'({4'd1, 2'd1, 2'd2, 2'd3}));

    // R6: MAD destination limited to vector file
    @(negedge clk); pim_en = 1'b0;
    hwrite(0, mk(4, 3, 1, 2, 0, 0));
    rearm();
    trig_once();
    chk("R6 MAD issue", 32'({issue_op, issue_dst, issue_src0, issue_src1, pc}),
        32'({4'd4, 2'd1, 2'd1, 2'd2, 5'd1}));
    @(negedge clk);
    chk("R11 MAD counted", 32'(lane_ops), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule